// File: doc/BRIEF.md
# Corner-Marker Overlay Join

This block sits at a reconvergent point in a streaming video pipeline. Each incoming RGB pixel is handed out twice. One copy leaves on a detector port toward an external feature-detection chain. That chain returns one 8-bit mask byte per pixel, in the same order. The other copy, with its start-of-frame and end-of-line flags, waits in a deep bypass FIFO. The FIFO absorbs the detector chain's latency, which can reach about ten lines of a full-HD frame. The painter then takes one bypassed pixel and one mask byte at a time. Where the mask byte is zero, the pixel goes out unchanged. Where it is nonzero, the pixel is replaced by a fixed overlay colour. The mask is typically a dilated corner map, so small regions around each detected feature appear painted.

All data interfaces use valid/ready handshakes. A beat moves on a rising clock edge where both valid and ready are high. A source holds valid and its data until the beat moves. The input is accepted only when the detector port and the FIFO can both take the pixel, so the two copies never differ in count. The detector port's valid is therefore a combinational function of FIFO space. The mask input waits while the FIFO is empty, and both joined streams wait while the output is stalled. FIFO depth is a parameter; deployments at 1920-pixel lines set it to 20000. The occupancy and the full/empty flags are plain status outputs.

Top module: `overlay_join`

## Requirements
- R1: After reset, out_valid is 0, fifo_empty is 1, fifo_full is 0 and fifo_level is 0.
- R2: An input pixel is accepted only in a cycle where det_ready is high and the FIFO is not full. Every accepted pixel appears exactly once on det_data, in arrival order. det_valid is low whenever the FIFO is full.
- R3: fifo_level equals accepted pixels minus emitted pixels. fifo_full is 1 exactly when the level equals DEPTH. While full, in_ready is 0 and no pixel is lost.
- R4: When the paired mask byte is 0, out_data equals the bypassed pixel bit for bit. The pixel is packed with channel 0 in bits [23:16], channel 1 in [15:8] and channel 2 in [7:0].
- R5: When the paired mask byte is any nonzero value (1 to 255), out_data is the overlay colour. By default this is channel 0 = 255 and channels 1 and 2 = 0, i.e. 24'hFF0000.
- R6: out_sof and out_eol equal the in_sof and in_eol that arrived with the same pixel, whether or not the pixel is painted.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data, out_sof and out_eol hold. Stalls lose or duplicate no pixel.
- R8: Exactly one mask byte is consumed per output pixel. msk_ready is 0 while the FIFO is empty.
- R9: With the output idle and a mask byte waiting, a pixel accepted at edge N appears on the output after edge N+1, and not after edge N.
- R10: The mask stream may lag the input by up to DEPTH pixels. The input is not stalled until DEPTH pixels are held, and everything held is then emitted in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_data | input | 24 | Input RGB pixel |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a line |
| det_valid | output | 1 | Copy for detector chain valid |
| det_ready | input | 1 | Detector chain can take a pixel |
| det_data | output | 24 | Copy of the input pixel |
| msk_valid | input | 1 | Mask byte valid |
| msk_ready | output | 1 | Mask byte consumed when high with msk_valid |
| msk_data | input | 8 | Mask byte, nonzero means paint |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream can take a pixel |
| out_data | output | 24 | Output RGB pixel |
| out_sof | output | 1 | Start-of-frame flag of output pixel |
| out_eol | output | 1 | End-of-line flag of output pixel |
| fifo_level | output | $clog2(DEPTH+1) | Pixels held in the bypass FIFO |
| fifo_full | output | 1 | Bypass FIFO holds DEPTH pixels |
| fifo_empty | output | 1 | Bypass FIFO holds nothing |

## Verification
A wrong FIFO pointer or level shows at the ports within one pass of the FIFO. Either a later output pixel differs from the pixel that entered at that position, or fifo_full rises at the wrong fill. Both are caught by filling the FIFO to DEPTH before any mask arrives. A skewed pairing between mask and bypass shifts the painted positions, so the first marked pixel comes out with the wrong colour. A lost flag shows on out_sof or out_eol at the next line end. A broken output register shows during the first stalled cycle, when the data changes or valid drops.

// File: rtl/ovj_pkg.sv
package ovj_pkg;
  parameter int unsigned CH_W = 8;
  parameter int unsigned N_CH = 3;
  localparam int unsigned PIX_W = CH_W * N_CH;
  localparam int unsigned MSK_W = CH_W;

  typedef logic [PIX_W-1:0] pix_t;
  typedef logic [MSK_W-1:0] msk_t;

  typedef struct packed {
    logic sof;
    logic eol;
    pix_t rgb;
  } beat_t;

  localparam int unsigned BEAT_W = $bits(beat_t);

  // channel k occupies the k-th byte counted from the top of the word
  function automatic int unsigned ch_lsb(int unsigned k);
    return PIX_W - (k + 1) * CH_W;
  endfunction
endpackage

// File: rtl/ovj_split.sv
module ovj_split
  import ovj_pkg::*;
(
  input  logic  in_valid,
  output logic  in_ready,
  input  pix_t  in_data,
  input  logic  in_sof,
  input  logic  in_eol,
  output logic  det_valid,
  input  logic  det_ready,
  output pix_t  det_data,
  input  logic  byp_space,
  output logic  byp_wr,
  output beat_t byp_beat
);
  // a pixel leaves only when both branches take it in the same cycle
  always_comb begin
    in_ready      = det_ready && byp_space;
    det_valid     = in_valid && byp_space;
    byp_wr        = in_valid && det_ready && byp_space;
    det_data      = in_data;
    byp_beat.sof  = in_sof;
    byp_beat.eol  = in_eol;
    byp_beat.rgb  = in_data;
  end
endmodule

// File: rtl/ovj_fifo.sv
module ovj_fifo #(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned W     = 26,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic          full,
  output logic          empty,
  output logic [LW-1:0] level
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] cnt;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_comb begin
    rd_data = mem[rd_ptr];
    full    = (cnt == FULL_LVL);
    empty   = (cnt == '0);
    level   = cnt;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty); // R8
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({full, empty})); // R3
  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en) |=> !empty); // R3
endmodule

// File: rtl/ovj_paint.sv
module ovj_paint
  import ovj_pkg::*;
#(
  parameter logic [CH_W-1:0] OVL_C0 = 8'hFF,
  parameter logic [CH_W-1:0] OVL_C1 = 8'h00,
  parameter logic [CH_W-1:0] OVL_C2 = 8'h00
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  byp_valid,
  input  beat_t byp_beat,
  output logic  byp_pop,
  input  logic  msk_valid,
  input  msk_t  msk_data,
  output logic  msk_ready,
  output logic  out_valid,
  input  logic  out_ready,
  output pix_t  out_data,
  output logic  out_sof,
  output logic  out_eol
);
  logic [CH_W-1:0] ovl [N_CH];
  logic            room;
  logic            hit;
  pix_t            painted;
  beat_t           o_q;
  logic            o_vld;

  always_comb begin
    ovl[0] = OVL_C0;
    ovl[1] = OVL_C1;
    ovl[2] = OVL_C2;
  end

  always_comb begin
    room      = !o_vld || out_ready;
    hit       = (msk_data != '0);
    msk_ready = byp_valid && room;
    byp_pop   = byp_valid && msk_valid && room;
  end

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    localparam int unsigned LSB = ch_lsb(k);
    assign painted[LSB +: CH_W] = hit ? ovl[k] : byp_beat.rgb[LSB +: CH_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_vld <= 1'b0;
      o_q   <= '0;
    end else if (byp_pop) begin
      o_vld   <= 1'b1;
      o_q.sof <= byp_beat.sof;
      o_q.eol <= byp_beat.eol;
      o_q.rgb <= painted;
    end else if (out_ready) begin
      o_vld <= 1'b0;
    end
  end

  always_comb begin
    out_valid = o_vld;
    out_data  = o_q.rgb;
    out_sof   = o_q.sof;
    out_eol   = o_q.eol;
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
      && $stable(out_sof) && $stable(out_eol))); // R7
  AST_MASK_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_valid && msk_ready) |-> byp_valid); // R8
  AST_OUT_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_valid && msk_ready) |=> out_valid); // R9
endmodule

// File: rtl/overlay_join.sv
module overlay_join
  import ovj_pkg::*;
#(
  parameter int unsigned DEPTH = 2048,
  parameter logic [7:0]  OVL_C0 = 8'hFF,
  parameter logic [7:0]  OVL_C1 = 8'h00,
  parameter logic [7:0]  OVL_C2 = 8'h00,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [23:0]      in_data,
  input  logic             in_sof,
  input  logic             in_eol,
  output logic             det_valid,
  input  logic             det_ready,
  output logic [23:0]      det_data,
  input  logic             msk_valid,
  output logic             msk_ready,
  input  logic [7:0]       msk_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [23:0]      out_data,
  output logic             out_sof,
  output logic             out_eol,
  output logic [LVL_W-1:0] fifo_level,
  output logic             fifo_full,
  output logic             fifo_empty
);
  logic  byp_wr, byp_pop;
  beat_t wr_beat, rd_beat;
  logic [BEAT_W-1:0] rd_raw;

  ovj_split u_split (
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_sof    (in_sof),
    .in_eol    (in_eol),
    .det_valid (det_valid),
    .det_ready (det_ready),
    .det_data  (det_data),
    .byp_space (!fifo_full),
    .byp_wr    (byp_wr),
    .byp_beat  (wr_beat)
  );

  ovj_fifo #(.DEPTH(DEPTH), .W(BEAT_W)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (byp_wr),
    .wr_data (wr_beat),
    .rd_en   (byp_pop),
    .rd_data (rd_raw),
    .full    (fifo_full),
    .empty   (fifo_empty),
    .level   (fifo_level)
  );

  assign rd_beat = beat_t'(rd_raw);

  ovj_paint #(.OVL_C0(OVL_C0), .OVL_C1(OVL_C1), .OVL_C2(OVL_C2)) u_paint (
    .clk       (clk),
    .rst_n     (rst_n),
    .byp_valid (!fifo_empty),
    .byp_beat  (rd_beat),
    .byp_pop   (byp_pop),
    .msk_valid (msk_valid),
    .msk_data  (msk_data),
    .msk_ready (msk_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sof   (out_sof),
    .out_eol   (out_eol)
  );

  AST_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (det_valid && det_ready)); // R2
  AST_DET_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !det_valid); // R2
endmodule

// File: tb/overlay_join_test.sv
module overlay_join_test;
  localparam int unsigned DEPTH = 32;
  localparam int unsigned LW = $clog2(DEPTH + 1);
  localparam int unsigned LINE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_sof = 0, in_eol = 0, det_ready = 0;
  logic [23:0] in_data = '0;
  logic msk_valid = 0, out_ready = 0;
  logic [7:0] msk_data = '0;
  logic in_ready, det_valid, msk_ready, out_valid, out_sof, out_eol;
  logic fifo_full, fifo_empty;
  logic [23:0] det_data, out_data;
  logic [LW-1:0] fifo_level;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int sent, mcnt, ocnt, dcnt;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  overlay_join #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eol(in_eol),
    .det_valid(det_valid), .det_ready(det_ready), .det_data(det_data),
    .msk_valid(msk_valid), .msk_ready(msk_ready), .msk_data(msk_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eol(out_eol),
    .fifo_level(fifo_level), .fifo_full(fifo_full), .fifo_empty(fifo_empty)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] pix(int i);
    logic [7:0] b = 8'(i);
    return {b ^ 8'h5A, b + 8'd3, ~b};
  endfunction

  function automatic logic [7:0] mval(int i, int mode);
    if (mode == 0) return 8'h00;
    if (mode == 2) return 8'hFF;
    if (i % 5 == 2) return (i % 2 == 1) ? 8'h01 : 8'hC8;
    return 8'h00;
  endfunction

  function automatic logic [23:0] expect_px(int i, int mode);
    return (mval(i, mode) != 0) ? 24'hFF0000 : pix(i);
  endfunction

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 fifo_empty", 32'(fifo_empty), 1);
    chk("R1 fifo_full", 32'(fifo_full), 0);
    chk("R1 fifo_level", 32'(fifo_level), 0);
  endtask

  // R2 R3 R4 R5 R6 R7 R10: full stream with lagging mask branch
  task automatic run_case(input int n, input int lag, input int mmode,
                          input int omode, input int dmode);
    sent = 0; mcnt = 0; ocnt = 0; dcnt = 0;
    fork
      begin : producer
        while (sent < n) begin
          @(negedge clk);
          det_ready = (dmode == 0) || (cyc % 4 != 1);
          in_valid = 1;
          in_data = pix(sent);
          in_sof = (sent == 0);
          in_eol = (sent % LINE == LINE - 1);
          #1;
          if (in_ready) sent++;
        end
        @(negedge clk);
        in_valid = 0;
        det_ready = 1;
      end
      begin : det_mon
        while (dcnt < n) begin
          @(negedge clk);
          #1;
          if (det_valid && det_ready) begin
            chk("R2 det_data", 32'(det_data), 32'(pix(dcnt)));
            dcnt++;
          end
        end
      end
      begin : masker
        wait (sent >= lag);
        if (lag >= DEPTH) begin
          @(negedge clk);
          #1;
          chk("R10 level at lag", 32'(fifo_level), DEPTH);
          chk("R3 full at lag", 32'(fifo_full), 1);
          chk("R3 in_ready while full", 32'(in_ready), 0);
          chk("R2 det_valid while full", 32'(det_valid), 0);
        end
        while (mcnt < n) begin
          @(negedge clk);
          msk_valid = 1;
          msk_data = mval(mcnt, mmode);
          #1;
          if (msk_ready) mcnt++;
        end
        @(negedge clk);
        msk_valid = 0;
      end
      begin : consumer
        while (ocnt < n) begin
          @(negedge clk);
          out_ready = (omode == 0) || (cyc % 3 != 0);
          #1;
          if (out_valid && out_ready) begin
            chk((mval(ocnt, mmode) != 0) ? "R5 painted" : "R4 passed",
                32'(out_data), 32'(expect_px(ocnt, mmode)));
            chk("R6 sof", 32'(out_sof), 32'(ocnt == 0));
            chk("R6 eol", 32'(out_eol), 32'(ocnt % LINE == LINE - 1));
          end
          if (out_valid && !out_ready) begin
            logic [23:0] held = out_data;
            @(negedge clk);
            out_ready = 1;
            #1;
            chk("R7 hold valid", 32'(out_valid), 1);
            chk("R7 hold data", 32'(out_data), 32'(held));
            chk("R7 stalled pixel", 32'(out_data), 32'(expect_px(ocnt, mmode)));
          end
          if (out_valid && out_ready) ocnt++;
        end
      end
    join
    @(negedge clk);
    #1;
    chk("R3 drained", 32'(fifo_empty), 1);
    chk("R8 no extra out", 32'(out_valid), 0);
  endtask

  // R8 R9: mask waits for pixel, then two-edge latency
  task automatic t_mask_first();
    @(negedge clk);
    out_ready = 1;
    msk_valid = 1;
    msk_data = 8'h07;
    #1;
    chk("R8 msk_ready empty", 32'(msk_ready), 0);
    repeat (3) begin
      @(negedge clk);
      #1;
      chk("R8 msk_ready stays low", 32'(msk_ready), 0);
      chk("R8 no output", 32'(out_valid), 0);
    end
    @(negedge clk);
    det_ready = 1; in_valid = 1; in_data = 24'h123456; in_sof = 1; in_eol = 1;
    #1;
    chk("R2 in_ready", 32'(in_ready), 1);
    @(negedge clk);
    in_valid = 0;
    #1;
    chk("R9 not yet", 32'(out_valid), 0);
    chk("R8 msk_ready now", 32'(msk_ready), 1);
    @(negedge clk);
    msk_valid = 0;
    #1;
    chk("R9 out_valid", 32'(out_valid), 1);
    chk("R5 colour", 32'(out_data), 32'h00FF0000);
    chk("R6 flags", 32'({out_sof, out_eol}), 32'h3);
    @(negedge clk);
    #1;
    chk("R8 single output", 32'(out_valid), 0);
    chk("R3 empty after", 32'(fifo_empty), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    run_case(40, 0, 0, 0, 0);
    run_case(60, 10, 1, 1, 1);
    run_case(70, DEPTH, 2, 0, 0);
    run_case(64, DEPTH, 1, 1, 0);
    t_mask_first();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule